// File: doc/BRIEF.md
# Dual-Output Data Register with Pipelined Cascadable Parity Check

This block moves a 12-bit word to two identical 12-bit output copies. It runs in one of two modes. In the first, the word is held in a register that loads on the rising clock edge. In the second, the input word goes straight to the outputs with no register in the path. A hold control can freeze the low eight bits of the register while the upper four bits keep loading.

Alongside the data path, a parity checker confirms each word against a parity bit. That bit comes one clock after the word it covers. The result of the check is registered one clock after the parity bit arrives. It appears on an error line that behaves like an open-drain output: the line is either pulled low or released.

Input bit 10 has two roles. It is an ordinary data bit, and it also acts as the load enable of the error register. A single parity port does one of two jobs:
- It selects even or odd parity.
- It links two instances: one drives its partial parity sum and the other folds that sum into its own check.

Three-state outputs are modelled as separate drive-enable signals.

Top module: `dreg_cascade_top`

## Requirements
- R1: With `pass_mode` high, `y0_val` equals `a_in` combinationally, with no clock edge needed.
- R2: With `pass_mode` low and `keep_low` low, a rising edge loads all 12 bits of `a_in` into the register, and the outputs show that word after the edge.
- R3: With `keep_low` high at a rising edge, bits 11..8 load from `a_in` and bits 7..0 keep their stored value.
- R4: The parity bit `pbit_in` for the word sampled at edge t is sampled at edge t+1, and the check result appears on `err_pull` right after edge t+1. This holds in both modes.
- R5: The error register loads a new result only at an edge where `a_in[10]` is low. When `a_in[10]` is high it keeps its value.
- R6: Both output copies `y0_val` and `y1_val` always carry the same word.
- R7: When `oe_n` is high, `y_drive` and `err_pull` are both 0. When `oe_n` is low, `y_drive` is 1.
- R8: When `par_oe` is high, a mismatch is defined as XOR(word bits) ^ `pbit_in` ^ `par_in` = 1. In standalone use, `par_in` = 0 selects even parity and 1 selects odd parity. With `oe_n` low, `err_pull` is 1 (the line is pulled low) exactly when the registered result is a mismatch.
- R9: When `par_oe` is low, `par_out_en` is 1, and `par_out` equals XOR(last sampled word) ^ current `pbit_in`. In that case the instance's own check uses even sense. When `par_oe` is high, `par_out_en` is 0, and a partial sum received on `par_in` from another instance joins the check.
- R10: A synchronous reset clears the data register and the parity stage, and releases the error line (`err_pull` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pass_mode | input | 1 | 1 = pass-through, 0 = registered |
| keep_low | input | 1 | 1 = freeze bits 7..0 at the edge |
| oe_n | input | 1 | Output enable, active low |
| a_in | input | 12 | Data word; bit 10 also gates the error register |
| pbit_in | input | 1 | Parity bit for the previous word |
| par_oe | input | 1 | 0 = drive partial sum, 1 = receive sense/sum |
| par_in | input | 1 | Sense select or partial sum from another instance |
| par_out | output | 1 | Partial parity sum |
| par_out_en | output | 1 | Drive enable of `par_out` |
| y0_val | output | 12 | First output copy |
| y1_val | output | 12 | Second output copy |
| y_drive | output | 1 | Drive enable for both copies |
| err_pull | output | 1 | 1 = error line pulled low, 0 = released |

## Verification
A stuck or wrongly loaded bit in the data register shows on both output copies right after the next rising edge. A wrong value in the one-bit parity stage shows up one edge later, and only as a wrong level on the error line. It stays hidden while bit 10 is high, and it is masked when `oe_n` is high. For that reason the bench runs a continuous model of both pipeline stages. It checks the error line after every edge over long word streams, under both parity senses, in both modes and with the cascade link. This way a stage fault is caught at the first ungated edge that follows it.

// File: rtl/dreg_pkg.sv
package dreg_pkg;
    parameter int unsigned DW   = 12;  // data word width
    parameter int unsigned HOLD = 8;   // bits frozen by keep_low
    parameter int unsigned GATE = 10;  // data bit gating the error register

    typedef struct packed {
        logic word_x;    // XOR of the word sampled at the last edge
        logic mismatch;  // registered check result, 1 = error
    } par_state_t;
endpackage

// File: rtl/dreg_capture.sv
module dreg_capture #(
    parameter int unsigned WIDTH     = dreg_pkg::DW,
    parameter int unsigned HOLD_BITS = dreg_pkg::HOLD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             keep_low,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] bit_load;
    logic [WIDTH-1:0] word_d, word_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (b < HOLD_BITS) begin : g_held
            assign bit_load[b] = ~keep_low;
        end else begin : g_free
            assign bit_load[b] = 1'b1;
        end
    end

    always_comb begin
        word_d = (word_q & ~bit_load) | (d_in & bit_load);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign q_out = word_q;
endmodule

// File: rtl/dreg_parity.sv
module dreg_parity #(
    parameter int unsigned WIDTH    = dreg_pkg::DW,
    parameter int unsigned GATE_BIT = dreg_pkg::GATE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] word_in,
    input  logic             pbit_in,
    input  logic             port_drive,
    input  logic             port_in,
    output logic             partial_out,
    output logic             mismatch_q
);
    import dreg_pkg::*;

    par_state_t st_d, st_q;
    logic       sense;
    logic       chk;

    always_comb begin
        st_d        = st_q;
        st_d.word_x = ^word_in;
        sense       = port_drive ? 1'b0 : port_in;
        chk         = st_q.word_x ^ pbit_in ^ sense;
        if (!word_in[GATE_BIT]) begin
            st_d.mismatch = chk;
        end
        partial_out = st_q.word_x ^ pbit_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mismatch_q = st_q.mismatch;
endmodule

// File: rtl/dreg_outs.sv
module dreg_outs #(
    parameter int unsigned WIDTH  = dreg_pkg::DW,
    parameter int unsigned COPIES = 2
) (
    input  logic                          oe_n,
    input  logic [WIDTH-1:0]              word,
    input  logic                          mismatch,
    output logic [COPIES-1:0][WIDTH-1:0]  copies,
    output logic                          y_drive,
    output logic                          err_pull
);
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        assign copies[c] = word;
    end

    assign y_drive  = ~oe_n;
    assign err_pull = mismatch & ~oe_n;
endmodule

// File: rtl/dreg_cascade_top.sv
module dreg_cascade_top #(
    parameter int unsigned WIDTH     = dreg_pkg::DW,
    parameter int unsigned HOLD_BITS = dreg_pkg::HOLD,
    parameter int unsigned GATE_BIT  = dreg_pkg::GATE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pass_mode,
    input  logic             keep_low,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic             pbit_in,
    input  logic             par_oe,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_out_en,
    output logic [WIDTH-1:0] y0_val,
    output logic [WIDTH-1:0] y1_val,
    output logic             y_drive,
    output logic             err_pull
);
    localparam int unsigned COPIES = 2;

    logic [WIDTH-1:0]             reg_word;
    logic [WIDTH-1:0]             out_word;
    logic [COPIES-1:0][WIDTH-1:0] copies;
    logic                         mismatch;
    logic                         port_drive;

    assign port_drive = ~par_oe;

    dreg_capture #(
        .WIDTH     (WIDTH),
        .HOLD_BITS (HOLD_BITS)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .keep_low (keep_low),
        .d_in     (a_in),
        .q_out    (reg_word)
    );

    dreg_parity #(
        .WIDTH    (WIDTH),
        .GATE_BIT (GATE_BIT)
    ) u_parity (
        .clk         (clk),
        .rst         (rst),
        .word_in     (a_in),
        .pbit_in     (pbit_in),
        .port_drive  (port_drive),
        .port_in     (par_in),
        .partial_out (par_out),
        .mismatch_q  (mismatch)
    );

    always_comb begin
        out_word = pass_mode ? a_in : reg_word;
    end

    dreg_outs #(
        .WIDTH  (WIDTH),
        .COPIES (COPIES)
    ) u_outs (
        .oe_n     (oe_n),
        .word     (out_word),
        .mismatch (mismatch),
        .copies   (copies),
        .y_drive  (y_drive),
        .err_pull (err_pull)
    );

    assign y0_val     = copies[0];
    assign y1_val     = copies[1];
    assign par_out_en = port_drive;
endmodule

// File: rtl/dreg_cascade_chk.sv
module dreg_cascade_chk #(
    parameter int unsigned WIDTH     = 12,
    parameter int unsigned HOLD_BITS = 8,
    parameter int unsigned GATE_BIT  = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             pass_mode,
    input logic             keep_low,
    input logic             oe_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] y0_val,
    input logic             y_drive,
    input logic             err_pull
);
    AST_PASS_DIRECT: assert property (@(posedge clk) disable iff (rst)
        pass_mode |-> (y0_val == a_in));  // R1

    AST_UPPER_LOADS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pass_mode || (y0_val[WIDTH-1:HOLD_BITS] == $past(a_in[WIDTH-1:HOLD_BITS]))));  // R2

    AST_LOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (keep_low && !pass_mode) |=> (pass_mode || (y0_val[HOLD_BITS-1:0] == $past(y0_val[HOLD_BITS-1:0]))));  // R3

    AST_ERR_GATED: assert property (@(posedge clk) disable iff (rst)
        (a_in[GATE_BIT] && !oe_n) |=> (oe_n || $stable(err_pull)));  // R5

    AST_HIZ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!y_drive && !err_pull));  // R7

    AST_RESET_RELEASE: assert property (@(posedge clk)
        rst |=> !err_pull);  // R10
endmodule

bind dreg_cascade_top dreg_cascade_chk #(
    .WIDTH     (WIDTH),
    .HOLD_BITS (HOLD_BITS),
    .GATE_BIT  (GATE_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pass_mode (pass_mode),
    .keep_low  (keep_low),
    .oe_n      (oe_n),
    .a_in      (a_in),
    .y0_val    (y0_val),
    .y_drive   (y_drive),
    .err_pull  (err_pull)
);

// File: tb/dreg_cascade_top_tb.sv
module dreg_cascade_top_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst = 1'b1;
    logic        pass_mode = 1'b0, keep_low = 1'b0, oe_n = 1'b0;
    logic [11:0] a_in = '0;
    logic        pbit = 1'b0;
    logic        sense = 1'b0, cascade_on = 1'b0;
    logic        dut_par_in, dut_par_out, dut_par_en;
    logic [11:0] y0, y1;
    logic        y_drive, err_pull;

    logic [11:0] src_a = '0;
    logic        src_p = 1'b0;
    logic        src_par_out, src_par_en;
    logic [11:0] src_y0, src_y1;
    logic        src_drive, src_err;

    assign dut_par_in = cascade_on ? src_par_out : sense;

    dreg_cascade_top u_dut (
        .clk(clk), .rst(rst), .pass_mode(pass_mode), .keep_low(keep_low), .oe_n(oe_n),
        .a_in(a_in), .pbit_in(pbit), .par_oe(1'b1), .par_in(dut_par_in),
        .par_out(dut_par_out), .par_out_en(dut_par_en), .y0_val(y0), .y1_val(y1),
        .y_drive(y_drive), .err_pull(err_pull)
    );

    dreg_cascade_top u_src (
        .clk(clk), .rst(rst), .pass_mode(1'b0), .keep_low(1'b0), .oe_n(1'b0),
        .a_in(src_a), .pbit_in(src_p), .par_oe(1'b0), .par_in(1'b0),
        .par_out(src_par_out), .par_out_en(src_par_en), .y0_val(src_y0), .y1_val(src_y1),
        .y_drive(src_drive), .err_pull(src_err)
    );

    int checks = 0, failures = 0;
    bit done = 1'b0;

    logic [11:0] reg_m = '0;
    logic        prev_x = 1'b0, src_prev_x = 1'b0, exp_err = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mix(input int i);
        int t;
        t = i * 2473 + 911;
        t = t ^ (t >>> 5) ^ (i * 77);
        return t[11:0];
    endfunction

    task automatic tick(input logic [11:0] w, input logic p, input logic [11:0] sw, input logic sp);
        logic eff;
        logic [11:0] exp_y;
        a_in = w; pbit = p; src_a = sw; src_p = sp;
        #1;
        if (pass_mode) check(y0 == w, "R1 pass-through", int'(y0), int'(w));
        if (cascade_on) begin
            check(src_par_out == (src_prev_x ^ sp), "R9 partial sum", int'(src_par_out), int'(src_prev_x ^ sp));
            check(src_par_en == 1'b1 && dut_par_en == 1'b0, "R9 port direction",
                  int'({src_par_en, dut_par_en}), 2);
        end
        eff = cascade_on ? (src_prev_x ^ sp) : sense;
        @(posedge clk);
        if (!w[10]) exp_err = prev_x ^ p ^ eff;  // R5 gate, R4 timing
        prev_x = ^w;
        src_prev_x = ^sw;
        if (keep_low) reg_m[11:8] = w[11:8];
        else reg_m = w;
        @(negedge clk);
        exp_y = pass_mode ? w : reg_m;
        check(y0 == exp_y, keep_low ? "R3 low bits held" : "R2 register load", int'(y0), int'(exp_y));
        check(y1 == y0, "R6 copies equal", int'(y1), int'(y0));
        check(err_pull == (exp_err & ~oe_n), cascade_on ? "R9 cascaded check" : "R4/R8 parity check",
              int'(err_pull), int'(exp_err & ~oe_n));
        check(y_drive == ~oe_n, "R7 drive enable", int'(y_drive), int'(~oe_n));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        a_in = 12'hFFF; pbit = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(y0 == 12'h000, "R10 register cleared", int'(y0), 0);
        check(err_pull == 1'b0, "R10 error released", int'(err_pull), 0);
        rst = 1'b0;

        // R2 full-word loads
        for (int i = 0; i < 200; i++) tick(mix(i), i[2], mix(i + 500), i[3]);
        // R3 low byte frozen
        tick(12'h0A5, 1'b0, 12'h0, 1'b0);
        keep_low = 1'b1;
        for (int i = 0; i < 100; i++) tick(mix(i + 1000), i[1], mix(i + 1300), i[0]);
        keep_low = 1'b0;
        // R1 pass-through, register still tracked
        pass_mode = 1'b1;
        for (int i = 0; i < 100; i++) begin
            keep_low = i[0];
            tick(mix(i + 2000), i[3], mix(i + 2100), i[1]);
        end
        pass_mode = 1'b0; keep_low = 1'b0;
        // R7 outputs released
        oe_n = 1'b1;
        for (int i = 0; i < 20; i++) tick(mix(i + 3000), i[0], mix(i), 1'b0);
        oe_n = 1'b0;
        // R8 both senses, correct and corrupted parity, both modes
        for (int s = 0; s < 2; s++) begin
            logic nxt_p;
            sense = s[0];
            nxt_p = 1'b0;
            for (int i = 0; i < 256; i++) begin
                logic [11:0] w;
                w = mix(i + 4000 + s * 300);
                pass_mode = i[4];
                tick(w, nxt_p, mix(i), 1'b0);
                nxt_p = (^w) ^ sense ^ (i % 3 == 0);
            end
        end
        pass_mode = 1'b0; sense = 1'b0;
        // R9 cascaded pair
        cascade_on = 1'b1;
        for (int i = 0; i < 256; i++) tick(mix(i + 6000), i[2] ^ i[5], mix(i + 7000), i[1] ^ i[4]);
        cascade_on = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule